// File: doc/BRIEF.md
# Shared-Term Carry Select Adder

This block adds two unsigned operands of a parameterised width together with a carry input. It returns the sum and a carry output. It does not use two ripple chains, one for each assumed carry. Instead, every bit position builds a single set of Boolean terms from its two operand bits: an exclusive-OR, an AND and an OR. The two possible sum bits and the two possible carry bits for that position are all taken from this one set.

A pair of two-input multiplexers at each position then chooses the real sum bit and the real carry. The carry that arrives from the position below drives the select of both multiplexers. The carry chosen at one position becomes the select for the position above it. All candidate terms are formed in parallel, so the only serial path is the chain of carry multiplexers. The external carry input steers bit 0, and the carry chosen at the top bit is the carry output.

A parameter can place one register stage on the sum and the carry output. That register has a synchronous, active-high reset. With the stage left out, the block is purely combinational.

Top module: `csel_adder`

## Requirements
- R1: At any bit position whose incoming carry is 0, the sum bit equals the exclusive-OR of the two operand bits.
- R2: At any bit position whose incoming carry is 1, the sum bit equals the inverted exclusive-OR (XNOR) of the two operand bits.
- R3: At any bit position whose incoming carry is 0, the carry passed upward equals the AND of the two operand bits.
- R4: At any bit position whose incoming carry is 1, the carry passed upward equals the OR of the two operand bits.
- R5: `cin_i` is the incoming carry of bit 0. The carry chosen at bit WIDTH-1 is `cout_o`, so a carry entering at bit 0 can ripple through every position to `cout_o`.
- R6: For every input combination, {cout_o, sum_o} equals a_i + b_i + cin_i taken as unsigned values. This holds at WIDTH = 8, 16 and 32.
- R7: With REG_OUT = 1, sum_o and cout_o show the result for the inputs present at the previous rising clock edge, and they hold that value until the next edge.
- R8: With REG_OUT = 1, a rising edge of clk with rst high clears sum_o and cout_o to 0. Raising rst between edges leaves the outputs unchanged until the next edge.
- R9: With REG_OUT = 0, clk and rst have no effect. The outputs follow the inputs combinationally even while rst is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The bench builds three copies of the block.

The first is combinational at WIDTH = 8, which makes every operand pair with both carry values reachable. That exhaustive sweep drives every bit position through both incoming-carry cases of R1 to R4. It also covers R9, because this copy receives the bench reset.

The second is combinational at WIDTH = 16. It is driven with corner patterns: all zeros, all ones, alternating bits and single-bit carry ripples, each with cin toggled. It then takes random vectors.

The third is registered at WIDTH = 32. It reaches the full-length carry ripple, one-cycle latency and reset timing. These are checked both by patterns and by random vectors.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Candidate outputs of one bit position, one pair for each value of the incoming carry.
    typedef struct packed {
        logic sum_c0;    // sum bit if incoming carry is 0
        logic sum_c1;    // sum bit if incoming carry is 1
        logic carry_c0;  // outgoing carry if incoming carry is 0
        logic carry_c1;  // outgoing carry if incoming carry is 1
    } cand_t;

endpackage

// File: rtl/csa_bit_terms.sv
module csa_bit_terms
    import csa_pkg::*;
(
    input  logic  a_bit,
    input  logic  b_bit,
    output cand_t cand
);

    logic x_term;
    logic and_term;
    logic or_term;

    // One shared term set feeds all four candidates.
    always_comb begin
        x_term        = a_bit ^ b_bit;
        and_term      = a_bit & b_bit;
        or_term       = a_bit | b_bit;
        cand.sum_c0   = x_term;
        cand.sum_c1   = ~x_term;
        cand.carry_c0 = and_term;
        cand.carry_c1 = or_term;
    end

endmodule

// File: rtl/csa_term_array.sv
module csa_term_array
    import csa_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_vec,
    input  logic [WIDTH-1:0] b_vec,
    output cand_t [WIDTH-1:0] cand_vec
);

    // All positions form their candidates in parallel.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        csa_bit_terms u_terms (
            .a_bit (a_vec[gi]),
            .b_bit (b_vec[gi]),
            .cand  (cand_vec[gi])
        );
    end

endmodule

// File: rtl/csa_select_chain.sv
module csa_select_chain
    import csa_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int CW   = WIDTH + 1
) (
    input  cand_t [WIDTH-1:0] cand_vec,
    input  logic              carry_in,
    output logic [WIDTH-1:0]  sum_vec,
    output logic [CW-1:0]     carry_vec
);

    assign carry_vec[0] = carry_in;

    // Incoming carry selects both muxes; the selected carry steers the next bit.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_mux
        always_comb begin
            sum_vec[gi]      = carry_vec[gi] ? cand_vec[gi].sum_c1   : cand_vec[gi].sum_c0;
            carry_vec[gi+1]  = carry_vec[gi] ? cand_vec[gi].carry_c1 : cand_vec[gi].carry_c0;
        end
    end

endmodule

// File: rtl/csel_adder.sv
module csel_adder
    import csa_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int CW = WIDTH + 1;

    cand_t [WIDTH-1:0] cand_w;
    logic  [WIDTH-1:0] sum_w;
    logic  [CW-1:0]    carry_w;

    csa_term_array #(.WIDTH(WIDTH)) u_terms (
        .a_vec    (a_i),
        .b_vec    (b_i),
        .cand_vec (cand_w)
    );

    csa_select_chain #(.WIDTH(WIDTH)) u_chain (
        .cand_vec  (cand_w),
        .carry_in  (cin_i),
        .sum_vec   (sum_w),
        .carry_vec (carry_w)
    );

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic [WIDTH-1:0] sum;
            logic             cout;
        } out_t;

        out_t out_d;
        out_t out_q;

        always_comb begin
            out_d = out_q;
            if (rst) begin
                out_d = '0;
            end else begin
                out_d.sum  = sum_w;
                out_d.cout = carry_w[WIDTH];
            end
        end

        always_ff @(posedge clk) begin
            out_q <= out_d;
        end

        assign sum_o  = out_q.sum;
        assign cout_o = out_q.cout;
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst;
        assign sum_o  = sum_w;
        assign cout_o = carry_w[WIDTH];
    end

endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
    parameter int WIDTH   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic [WIDTH:0]   carry,
    input logic [WIDTH-1:0] sum_raw
);

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        AST_SUM_XOR: assert property (@(posedge clk) disable iff (rst)
            !carry[gi] |-> sum_raw[gi] == (a_i[gi] ^ b_i[gi])); // R1
        AST_SUM_XNOR: assert property (@(posedge clk) disable iff (rst)
            carry[gi] |-> sum_raw[gi] == !(a_i[gi] ^ b_i[gi])); // R2
        AST_CARRY_AND: assert property (@(posedge clk) disable iff (rst)
            !carry[gi] |-> carry[gi+1] == (a_i[gi] & b_i[gi])); // R3
        AST_CARRY_OR: assert property (@(posedge clk) disable iff (rst)
            carry[gi] |-> carry[gi+1] == (a_i[gi] | b_i[gi])); // R4
    end

    AST_CIN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        carry[0] == cin_i); // R5

    if (REG_OUT) begin : g_reg_chk
        AST_REG_TOTAL: assert property (@(posedge clk) disable iff (rst)
            !rst |=> {cout_o, sum_o} == $past({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})); // R7
        AST_RESET_CLEAR: assert property (@(posedge clk)
            rst |=> (sum_o == '0) && !cout_o); // R8
    end else begin : g_comb_chk
        AST_COMB_TOTAL: assert property (@(posedge clk)
            {cout_o, sum_o} == {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}); // R9
    end

endmodule

bind csel_adder csel_adder_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .carry   (carry_w),
    .sum_raw (sum_w)
);

// File: tb/sim_csel_adder.sv
`timescale 1ns/1ps
module sim_csel_adder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int n_vec  = 0;
    int n_fail = 0;

    logic [7:0]  a8  = '0, b8  = '0;  logic c8  = 1'b0;
    logic [15:0] a16 = '0, b16 = '0;  logic c16 = 1'b0;
    logic [31:0] a32 = '0, b32 = '0;  logic c32 = 1'b0;
    logic [7:0]  s8;  logic co8;
    logic [15:0] s16; logic co16;
    logic [31:0] s32; logic co32;

    csel_adder #(.WIDTH(8),  .REG_OUT(1'b0)) u0 (
        .clk(clk), .rst(rst), .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8));
    csel_adder #(.WIDTH(16), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst(rst), .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16));
    csel_adder #(.WIDTH(32), .REG_OUT(1'b1)) u2 (
        .clk(clk), .rst(rst), .a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32), .cout_o(co32));

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply8(input logic [7:0] a, input logic [7:0] b, input logic c, input string req);
        a8 = a; b8 = b; c8 = c;
        #1;
        check(req, {24'h0, co8, s8}, {25'h0, a} + {25'h0, b} + {32'h0, c});
    endtask

    task automatic apply16(input logic [15:0] a, input logic [15:0] b, input logic c, input string req);
        a16 = a; b16 = b; c16 = c;
        #1;
        check(req, {16'h0, co16, s16}, {17'h0, a} + {17'h0, b} + {32'h0, c});
    endtask

    // Drive at a falling edge; result registered at the next rising edge, sampled at the following falling edge.
    task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic c, input string req);
        @(negedge clk);
        a32 = a; b32 = b; c32 = c;
        @(negedge clk);
        check(req, {co32, s32}, {1'b0, a} + {1'b0, b} + {32'h0, c});
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", {co32, s32}, 33'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_bit_rules();
        apply8(8'h01, 8'h00, 1'b0, "R1");
        apply8(8'h01, 8'h01, 1'b1, "R2");
        apply8(8'h80, 8'h80, 1'b0, "R3");
        apply8(8'h01, 8'h00, 1'b1, "R4");
        apply8(8'hFF, 8'h00, 1'b1, "R5");
    endtask

    task automatic t_exhaustive8();
        for (int ai = 0; ai < 256; ai++)
            for (int bi = 0; bi < 256; bi++)
                for (int ci = 0; ci < 2; ci++)
                    apply8(ai[7:0], bi[7:0], ci[0], "R6");
    endtask

    task automatic t_comb_ignores_reset();
        rst = 1'b1;
        apply8(8'hA5, 8'h3C, 1'b1, "R9");
        apply8(8'hFF, 8'h01, 1'b0, "R9");
        @(negedge clk);
        apply8(8'h7F, 8'h80, 1'b1, "R9");
        rst = 1'b0;
    endtask

    task automatic t_corners16();
        for (int ci = 0; ci < 2; ci++) begin
            apply16(16'h0000, 16'h0000, ci[0], "R6");
            apply16(16'hFFFF, 16'hFFFF, ci[0], "R6");
            apply16(16'hAAAA, 16'h5555, ci[0], "R5");
            apply16(16'h5555, 16'h5555, ci[0], "R6");
            apply16(16'hFFFF, 16'h0000, ci[0], "R5");
        end
        for (int k = 0; k < 2000; k++)
            apply16(16'($urandom), 16'($urandom), 1'($urandom), "R6");
    endtask

    task automatic t_corners32();
        for (int ci = 0; ci < 2; ci++) begin
            apply32(32'h0, 32'h0, ci[0], "R7");
            apply32(32'hFFFF_FFFF, 32'hFFFF_FFFF, ci[0], "R7");
            apply32(32'hAAAA_AAAA, 32'h5555_5555, ci[0], "R5");
            apply32(32'hFFFF_FFFF, 32'h0, ci[0], "R5");
        end
        for (int k = 0; k < 2000; k++)
            apply32($urandom, $urandom, 1'($urandom), "R6");
        // Output holds while no edge occurs.
        @(negedge clk);
        a32 = 32'h1234_5678; b32 = 32'h1111_1111; c32 = 1'b1;
        @(negedge clk);
        a32 = 32'h0; b32 = 32'h0; c32 = 1'b0;
        #1;
        check("R7", {co32, s32}, 33'h0_2345_678A);
    endtask

    task automatic t_sync_reset();
        apply32(32'hDEAD_BEEF, 32'h0101_0101, 1'b1, "R7");
        rst = 1'b1;
        #1;
        check("R8", {co32, s32}, 33'h0_DFAE_BFF1);
        @(negedge clk);
        check("R8", {co32, s32}, 33'h0);
        rst = 1'b0;
    endtask

    initial begin
        #900000;
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_bit_rules();
        t_exhaustive8();
        t_comb_ignores_reset();
        t_corners16();
        t_corners32();
        t_sync_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule